// File: doc/BRIEF.md
# Enable-Gated Address Window Decoder

This block holds the configuration for three address windows and tells, for any address placed on its lookup port, which windows that address falls in and how far into the window it lies. Two of the windows are memory windows whose size is set by a mask register. The third is a register window of fixed size 0x1000 with no mask. Software programs base, mask and enable registers through a 64-bit register port that only takes full 8-byte accesses.

The base and mask registers hold values that sit 14 bits to the left of the address they describe. A window's effective base is its base register shifted right by 14. A memory window's size is its mask register inverted, shifted right by 14, plus one. Writes drop the low bits that each register does not implement. A sticky error flag records writes to undefined register numbers. It also records attempts to change the base or mask of a window that is live. Such a write is still stored, but the live window does not move: the decoded base and size are captured only when the enable register is written.

Top module: `addr_window_decoder`

## Requirements
- R1: An access is accepted only when `acc_bytes` is 8 and `acc_addr[2:0]` is zero; the register number is `acc_addr` divided by 8. Rejected accesses change no state, and `acc_rdata` is zero during them. `acc_rdata` is zero except during an accepted read.
- R2: Register numbers 0 (memory window 0 base), 1 (memory window 0 mask), 2 (memory window 1 base) and 3 (memory window 1 mask) keep only bits 63:30 of written data; lower bits read back as zero.
- R3: Register number 4 (register window base) keeps only bits 63:26 of written data.
- R4: Register number 5 (enable) keeps only bits 63:59; bit 63 enables memory window 0, bit 62 enables memory window 1, bit 61 enables the register window.
- R5: A window's base is its base register shifted right by 14. A memory window's size is (inverted mask >> 14) + 1. The register window's size is 0x1000.
- R6: `lk_hit[0]` (memory window 0), `lk_hit[1]` (memory window 1) and `lk_hit[2]` (register window) are set combinationally only when that window is enabled and base <= `lk_addr` < base + size. `lk_offset` is `lk_addr` minus the base of the lowest-numbered hit window, and is zero when nothing hits.
- R7: A write to registers 0 to 3 while either memory window is enabled sets the sticky error flag. So does a write to register 4 while the register window is enabled. In both cases the written value is still stored. With those enables clear, such writes leave the flag alone.
- R8: An accepted write to an undefined register number (6 or 7) sets the error flag and changes no register. An accepted read of such a number returns zero.
- R9: A synchronous active-high reset loads the default base and mask parameters (with the R2/R3 bit filters applied), clears all enable bits and clears the error flag.
- R10: Decoded base and size are captured when the enable register is written. Later base or mask writes do not move an enabled window until the enable register is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ACC_AW | Byte address of the register access |
| acc_bytes | input | ACC_BW | Access size in bytes; only 8 is accepted |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data, combinational |
| err_flag | output | 1 | Sticky programming-error flag |
| lk_addr | input | 64 | Address to decode |
| lk_hit | output | 3 | Per-window hit flags |
| lk_offset | output | 64 | Offset of lk_addr into the selected hit window |

## Verification
The hardest situation to reach is a window whose live decode no longer matches its base register. The stimulus first enables a window, then rewrites that window's base while the window is live, and looks up both the old and the new base before and after the enable register is written again. Overlapping memory windows are also built on purpose, so that the offset priority between them is visible. The error flag is exercised in three separate reset phases. One phase covers an undefined register number, one a protected write, and one a write that looks protected but is not, because only the other kind of window is enabled. A behavioural model in the bench predicts read data, hits, offset and the flag on every cycle.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;

    localparam int DW          = 64;
    localparam int NWIN        = 3;
    localparam int IX_W        = 3;
    localparam int WORD_BYTES  = 8;
    localparam int WORD_LSB    = $clog2(WORD_BYTES);
    localparam int DEC_SHIFT   = 14;
    localparam int MEM_KEEP_LO = 30;
    localparam int RW_KEEP_LO  = 26;
    localparam int EN_KEEP_LO  = 59;
    localparam logic [DW-1:0] RW_SPAN = 64'h1000;

    // window numbering used by hit vector and decode set
    localparam int W_M0 = 0;
    localparam int W_M1 = 1;
    localparam int W_RW = 2;

    // enable bit positions inside the enable register
    localparam int EN_BIT_M0 = 63;
    localparam int EN_BIT_M1 = 62;
    localparam int EN_BIT_RW = 61;

    typedef enum logic [IX_W-1:0] {
        IX_M0_BASE = 3'd0,
        IX_M0_MASK = 3'd1,
        IX_M1_BASE = 3'd2,
        IX_M1_MASK = 3'd3,
        IX_RW_BASE = 3'd4,
        IX_ENABLE  = 3'd5
    } reg_ix_e;

    typedef struct packed {
        logic            ok;
        logic            wr;
        logic            rd;
        logic [IX_W-1:0] ix;
    } acc_t;

    typedef struct packed {
        logic [DW-1:0] m0_base;
        logic [DW-1:0] m0_mask;
        logic [DW-1:0] m1_base;
        logic [DW-1:0] m1_mask;
        logic [DW-1:0] rw_base;
        logic [DW-1:0] enable;
    } cfg_regs_t;

    typedef struct packed {
        logic [DW-1:0] base;
        logic [DW:0]   limit;
    } win_t;

    typedef win_t [NWIN-1:0] win_set_t;

    function automatic logic [DW-1:0] keep_from(input logic [DW-1:0] v, input int lo);
        return v & ({DW{1'b1}} << lo);
    endfunction

    function automatic win_t decode_masked(input logic [DW-1:0] base_raw,
                                           input logic [DW-1:0] mask_raw);
        win_t w;
        w.base  = base_raw >> DEC_SHIFT;
        w.limit = {1'b0, w.base} + {1'b0, (~mask_raw) >> DEC_SHIFT} + (DW+1)'(1);
        return w;
    endfunction

    function automatic win_t decode_fixed(input logic [DW-1:0] base_raw,
                                          input logic [DW-1:0] span);
        win_t w;
        w.base  = base_raw >> DEC_SHIFT;
        w.limit = {1'b0, w.base} + {1'b0, span};
        return w;
    endfunction

    function automatic win_set_t decode_all(input cfg_regs_t r);
        win_set_t s;
        s[W_M0] = decode_masked(r.m0_base, r.m0_mask);
        s[W_M1] = decode_masked(r.m1_base, r.m1_mask);
        s[W_RW] = decode_fixed(r.rw_base, RW_SPAN);
        return s;
    endfunction

    function automatic cfg_regs_t build_defaults(input logic [DW-1:0] m0b,
                                                 input logic [DW-1:0] m0m,
                                                 input logic [DW-1:0] m1b,
                                                 input logic [DW-1:0] m1m,
                                                 input logic [DW-1:0] rwb);
        cfg_regs_t r;
        r.m0_base = keep_from(m0b, MEM_KEEP_LO);
        r.m0_mask = keep_from(m0m, MEM_KEEP_LO);
        r.m1_base = keep_from(m1b, MEM_KEEP_LO);
        r.m1_mask = keep_from(m1m, MEM_KEEP_LO);
        r.rw_base = keep_from(rwb, RW_KEEP_LO);
        r.enable  = '0;
        return r;
    endfunction

endpackage

// File: rtl/awd_access.sv
module awd_access
    import addr_win_pkg::*;
#(
    parameter int AW = 6,
    parameter int BW = 4
) (
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [BW-1:0] bytes,
    output acc_t          acc
);

    logic size_ok;
    logic align_ok;

    assign size_ok  = (bytes == BW'(WORD_BYTES));
    assign align_ok = (addr[WORD_LSB-1:0] == '0);

    always_comb begin
        acc.ok = valid && size_ok && align_ok;
        acc.wr = acc.ok && write;
        acc.rd = acc.ok && !write;
        acc.ix = IX_W'(addr >> WORD_LSB);
    end

endmodule

// File: rtl/awd_regfile.sv
module awd_regfile
    import addr_win_pkg::*;
#(
    parameter cfg_regs_t DEF_REGS = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  acc_t            acc,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            err,
    output cfg_regs_t       regs,
    output logic [NWIN-1:0] win_en,
    output logic            en_load
);

    cfg_regs_t regs_q;
    logic      err_q;
    logic      mem_live;
    logic      rw_live;

    assign mem_live = regs_q.enable[EN_BIT_M0] || regs_q.enable[EN_BIT_M1];
    assign rw_live  = regs_q.enable[EN_BIT_RW];

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= DEF_REGS;
            err_q  <= 1'b0;
        end else if (acc.wr) begin
            case (acc.ix)
                IX_M0_BASE: begin
                    regs_q.m0_base <= keep_from(wdata, MEM_KEEP_LO);
                    if (mem_live) err_q <= 1'b1;
                end
                IX_M0_MASK: begin
                    regs_q.m0_mask <= keep_from(wdata, MEM_KEEP_LO);
                    if (mem_live) err_q <= 1'b1;
                end
                IX_M1_BASE: begin
                    regs_q.m1_base <= keep_from(wdata, MEM_KEEP_LO);
                    if (mem_live) err_q <= 1'b1;
                end
                IX_M1_MASK: begin
                    regs_q.m1_mask <= keep_from(wdata, MEM_KEEP_LO);
                    if (mem_live) err_q <= 1'b1;
                end
                IX_RW_BASE: begin
                    regs_q.rw_base <= keep_from(wdata, RW_KEEP_LO);
                    if (rw_live) err_q <= 1'b1;
                end
                IX_ENABLE: begin
                    regs_q.enable <= keep_from(wdata, EN_KEEP_LO);
                end
                default: begin
                    err_q <= 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (acc.rd) begin
            case (acc.ix)
                IX_M0_BASE: rdata = regs_q.m0_base;
                IX_M0_MASK: rdata = regs_q.m0_mask;
                IX_M1_BASE: rdata = regs_q.m1_base;
                IX_M1_MASK: rdata = regs_q.m1_mask;
                IX_RW_BASE: rdata = regs_q.rw_base;
                IX_ENABLE:  rdata = regs_q.enable;
                default:    rdata = '0;
            endcase
        end
    end

    assign en_load      = acc.wr && (acc.ix == IX_ENABLE);
    assign err          = err_q;
    assign regs         = regs_q;
    assign win_en[W_M0] = regs_q.enable[EN_BIT_M0];
    assign win_en[W_M1] = regs_q.enable[EN_BIT_M1];
    assign win_en[W_RW] = regs_q.enable[EN_BIT_RW];

endmodule

// File: rtl/awd_win_latch.sv
module awd_win_latch
    import addr_win_pkg::*;
#(
    parameter cfg_regs_t DEF_REGS = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  cfg_regs_t regs,
    output win_set_t  wins
);

    localparam win_set_t DEF_WINS = decode_all(DEF_REGS);

    win_set_t wins_q;
    win_set_t wins_d;

    assign wins_d = decode_all(regs);

    always_ff @(posedge clk) begin
        if (rst) begin
            wins_q <= DEF_WINS;
        end else if (load) begin
            wins_q <= wins_d;
        end
    end

    assign wins = wins_q;

endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
    import addr_win_pkg::*;
(
    input  logic [NWIN-1:0] win_en,
    input  win_set_t        wins,
    input  logic [DW-1:0]   addr,
    output logic [NWIN-1:0] hit,
    output logic [DW-1:0]   offset
);

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        logic above_base;
        logic below_limit;
        assign above_base  = (addr >= wins[g].base);
        assign below_limit = ({1'b0, addr} < wins[g].limit);
        assign hit[g]      = win_en[g] && above_base && below_limit;
    end

    // lowest-numbered hit window selects the offset
    always_comb begin
        offset = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hit[i]) offset = addr - wins[i].base;
        end
    end

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import addr_win_pkg::*;
#(
    parameter int          ACC_AW      = IX_W + WORD_LSB,
    parameter int          ACC_BW      = 4,
    parameter logic [63:0] DEF_M0_BASE = 64'h0000_1000_0000_0000,
    parameter logic [63:0] DEF_M0_MASK = 64'hFFFF_FFFC_0000_0000,
    parameter logic [63:0] DEF_M1_BASE = 64'h0000_2000_0000_0000,
    parameter logic [63:0] DEF_M1_MASK = 64'hFFFF_FFFF_C000_0000,
    parameter logic [63:0] DEF_RW_BASE = 64'h0000_4000_0000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ACC_AW-1:0] acc_addr,
    input  logic [ACC_BW-1:0] acc_bytes,
    input  logic [63:0]       acc_wdata,
    output logic [63:0]       acc_rdata,
    output logic              err_flag,
    input  logic [63:0]       lk_addr,
    output logic [2:0]        lk_hit,
    output logic [63:0]       lk_offset
);

    localparam cfg_regs_t DEF_REGS =
        build_defaults(DEF_M0_BASE, DEF_M0_MASK, DEF_M1_BASE, DEF_M1_MASK, DEF_RW_BASE);

    acc_t            acc;
    cfg_regs_t       regs;
    win_set_t        wins;
    logic [NWIN-1:0] win_en;
    logic            en_load;

    awd_access #(.AW(ACC_AW), .BW(ACC_BW)) u_access (
        .valid (acc_valid),
        .write (acc_write),
        .addr  (acc_addr),
        .bytes (acc_bytes),
        .acc   (acc)
    );

    awd_regfile #(.DEF_REGS(DEF_REGS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .wdata   (acc_wdata),
        .rdata   (acc_rdata),
        .err     (err_flag),
        .regs    (regs),
        .win_en  (win_en),
        .en_load (en_load)
    );

    awd_win_latch #(.DEF_REGS(DEF_REGS)) u_latch (
        .clk  (clk),
        .rst  (rst),
        .load (en_load),
        .regs (regs),
        .wins (wins)
    );

    awd_win_match u_match (
        .win_en (win_en),
        .wins   (wins),
        .addr   (lk_addr),
        .hit    (lk_hit),
        .offset (lk_offset)
    );

endmodule

// File: rtl/addr_window_decoder_chk.sv
module addr_window_decoder_chk
    import addr_win_pkg::*;
#(
    parameter int AW = 6,
    parameter int BW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          acc_valid,
    input logic          acc_write,
    input logic [AW-1:0] acc_addr,
    input logic [BW-1:0] acc_bytes,
    input logic [63:0]   acc_rdata,
    input logic          err_flag,
    input logic [2:0]    lk_hit,
    input logic [63:0]   lk_offset
);

    logic            good;
    logic [IX_W-1:0] ix;

    assign good = acc_valid && (acc_bytes == BW'(WORD_BYTES)) && (acc_addr[WORD_LSB-1:0] == '0);
    assign ix   = IX_W'(acc_addr >> WORD_LSB);

    p_reject_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !good) |-> (acc_rdata == '0));

    p_mem_lowbits_r2: assert property (@(posedge clk) disable iff (rst)
        (good && !acc_write && ix <= 3'd3) |-> (acc_rdata[MEM_KEEP_LO-1:0] == '0));

    p_rw_lowbits_r3: assert property (@(posedge clk) disable iff (rst)
        (good && !acc_write && ix == 3'd4) |-> (acc_rdata[RW_KEEP_LO-1:0] == '0));

    p_en_lowbits_r4: assert property (@(posedge clk) disable iff (rst)
        (good && !acc_write && ix == 3'd5) |-> (acc_rdata[EN_KEEP_LO-1:0] == '0));

    p_nohit_offset_r6: assert property (@(posedge clk) disable iff (rst)
        (lk_hit == '0) |-> (lk_offset == '0));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    p_undef_err_r8: assert property (@(posedge clk) disable iff (rst)
        (good && acc_write && ix >= 3'd6) |=> err_flag);

    p_undef_read_r8: assert property (@(posedge clk) disable iff (rst)
        (good && !acc_write && ix >= 3'd6) |-> (acc_rdata == '0));

    p_reset_clean_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!err_flag && lk_hit == '0));

endmodule

bind addr_window_decoder addr_window_decoder_chk #(.AW(ACC_AW), .BW(ACC_BW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_bytes (acc_bytes),
    .acc_rdata (acc_rdata),
    .err_flag  (err_flag),
    .lk_hit    (lk_hit),
    .lk_offset (lk_offset)
);

// File: tb/test_addr_window_decoder.sv
`timescale 1ns/1ps
module test_addr_window_decoder;

    localparam logic [63:0] P_M0B = 64'h0000_1000_0000_0000; // base 0x4000_0000
    localparam logic [63:0] P_M0M = 64'hFFFF_FFFC_0000_0000; // size 0x10_0000
    localparam logic [63:0] P_M1B = 64'h0000_2000_0000_0000; // base 0x8000_0000
    localparam logic [63:0] P_M1M = 64'hFFFF_FFFF_C000_0000; // size 0x1_0000
    localparam logic [63:0] P_RWB = 64'h0000_4000_03FF_FFFF; // base 0x1_0000_0000

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [5:0]  acc_addr = '0;
    logic [3:0]  acc_bytes = '0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] acc_rdata;
    logic        err_flag;
    logic [63:0] lk_addr = '0;
    logic [2:0]  lk_hit;
    logic [63:0] lk_offset;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    addr_window_decoder #(
        .DEF_M0_BASE(P_M0B), .DEF_M0_MASK(P_M0M), .DEF_M1_BASE(P_M1B),
        .DEF_M1_MASK(P_M1M), .DEF_RW_BASE(P_RWB)
    ) i_addr_window_decoder (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_bytes(acc_bytes), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .err_flag(err_flag), .lk_addr(lk_addr),
        .lk_hit(lk_hit), .lk_offset(lk_offset)
    );

    // ---------------- behavioural reference model ----------------
    bit [63:0] m_reg [6];
    bit [63:0] m_base [3];
    bit [63:0] m_lim [3];
    bit        m_err;

    function automatic bit [63:0] lowclr(bit [63:0] v, int lo);
        bit [63:0] r = v;
        for (int i = 0; i < lo; i++) r[i] = 1'b0;
        return r;
    endfunction

    function automatic int keep_lo(int idx);
        if (idx <= 3) return 30;
        if (idx == 4) return 26;
        return 59;
    endfunction

    task automatic m_capture();
        m_base[0] = m_reg[0] >> 14; m_lim[0] = m_base[0] + ((~m_reg[1]) >> 14) + 1;
        m_base[1] = m_reg[2] >> 14; m_lim[1] = m_base[1] + ((~m_reg[3]) >> 14) + 1;
        m_base[2] = m_reg[4] >> 14; m_lim[2] = m_base[2] + 64'h1000;
    endtask

    task automatic m_reset();
        m_reg[0] = lowclr(P_M0B, 30); m_reg[1] = lowclr(P_M0M, 30);
        m_reg[2] = lowclr(P_M1B, 30); m_reg[3] = lowclr(P_M1M, 30);
        m_reg[4] = lowclr(P_RWB, 26); m_reg[5] = 64'h0;
        m_err = 1'b0;
        m_capture();
    endtask

    function automatic bit m_ok(bit v, bit [5:0] a, bit [3:0] b);
        return v && (b == 4'd8) && (a[2:0] == 3'd0);
    endfunction

    task automatic m_outputs(output bit [63:0] rd, output bit [2:0] hit, output bit [63:0] off);
        int idx = int'(acc_addr[5:3]);
        rd = 64'h0;
        if (m_ok(acc_valid, acc_addr, acc_bytes) && !acc_write && idx < 6) rd = m_reg[idx];
        hit = 3'b000; off = 64'h0;
        for (int i = 0; i < 3; i++)
            hit[i] = m_reg[5][63-i] && (lk_addr >= m_base[i]) && (lk_addr < m_lim[i]);
        for (int i = 2; i >= 0; i--)
            if (hit[i]) off = lk_addr - m_base[i];
    endtask

    task automatic m_clock();
        int idx = int'(acc_addr[5:3]);
        if (rst) begin
            m_reset();
        end else if (m_ok(acc_valid, acc_addr, acc_bytes) && acc_write) begin
            if (idx >= 6) m_err = 1'b1;
            else begin
                if (idx <= 3 && (m_reg[5][63] || m_reg[5][62])) m_err = 1'b1;
                if (idx == 4 && m_reg[5][61]) m_err = 1'b1;
                m_reg[idx] = lowclr(acc_wdata, keep_lo(idx));
                if (idx == 5) m_capture();
            end
        end
    endtask

    // ---------------- checking ----------------
    task automatic chk(string tag, string what, bit [63:0] act, bit [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit r, bit v, bit w, bit [5:0] a, bit [3:0] b,
                        bit [63:0] d, string tag);
        bit [63:0] erd, eoff;
        bit [2:0]  ehit;
        rst = r; acc_valid = v; acc_write = w; acc_addr = a; acc_bytes = b; acc_wdata = d;
        #5;
        m_outputs(erd, ehit, eoff);
        chk(tag, "acc_rdata", acc_rdata, erd);
        chk(tag, "lk_hit", {61'h0, lk_hit}, {61'h0, ehit});
        chk(tag, "lk_offset", lk_offset, eoff);
        chk(tag, "err_flag", {63'h0, err_flag}, {63'h0, m_err});
        @(posedge clk);
        m_clock();
        @(negedge clk);
    endtask

    task automatic do_reset(string tag);
        step(1, 0, 0, 0, 0, 0, tag);
        step(1, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic wr(bit [5:0] a, bit [63:0] d, string tag); step(0, 1, 1, a, 8, d, tag); endtask
    task automatic rd(bit [5:0] a, string tag); step(0, 1, 0, a, 8, 0, tag); endtask
    task automatic look(bit [63:0] la, string tag); lk_addr = la; step(0, 0, 0, 0, 0, 0, tag); endtask

    initial begin
        @(negedge clk); @(negedge clk);
        m_reset();
        // Phase A: reset state, access filtering, bit filters, undefined numbers
        do_reset("R9");
        for (int i = 0; i < 6; i++) rd(6'(i * 8), "R9");
        look(64'h4000_0000, "R9");
        step(0, 1, 1, 6'd0, 4'd4, '1, "R1");      // wrong size
        rd(6'd0, "R1");
        step(0, 1, 1, 6'd1, 4'd8, '1, "R1");      // misaligned
        step(0, 1, 0, 6'd1, 4'd8, 0, "R1");
        rd(6'd0, "R1");
        wr(6'd0, 64'h0000_3000_FFFF_FFFF, "R2");
        rd(6'd0, "R2");
        wr(6'd24, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        rd(6'd24, "R2");
        wr(6'd32, 64'h0000_5000_0FFF_FFFF, "R3");
        rd(6'd32, "R3");
        wr(6'd48, '1, "R8");
        wr(6'd56, '1, "R8");
        for (int i = 0; i < 8; i++) rd(6'(i * 8), "R8");

        // Phase B: enables, decode, hits, protection and capture
        do_reset("R9");
        wr(6'd40, '1, "R4");
        rd(6'd40, "R4");
        look(64'h3FFF_FFFF, "R5"); look(64'h4000_0000, "R5");
        look(64'h400F_FFFF, "R5"); look(64'h4010_0000, "R5");
        look(64'h7FFF_FFFF, "R5"); look(64'h8000_0000, "R5");
        look(64'h8000_FFFF, "R5"); look(64'h8001_0000, "R5");
        look(64'hFFFF_FFFF, "R5"); look(64'h1_0000_0000, "R5");
        look(64'h1_0000_0FFF, "R5"); look(64'h1_0000_1000, "R5");
        wr(6'd40, 0, "R4");
        look(64'h4000_0000, "R6");
        wr(6'd16, 64'h0000_1003_C000_0000, "R6");   // memory window 1 inside window 0
        wr(6'd40, 64'hC000_0000_0000_0000, "R4");
        look(64'h400F_0010, "R6"); look(64'h400E_FFFF, "R6");
        look(64'h1_0000_0000, "R4");
        for (int i = 0; i < 40; i++) look(64'h400E_F000 + 64'(i) * 64'h0800, "R6");
        wr(6'd32, 64'h0000_8000_0000_0000, "R7");   // register window off: no error
        rd(6'd32, "R7");
        wr(6'd0, 64'h0000_2000_0000_0000, "R7");    // protected write
        rd(6'd0, "R7");
        look(64'h4000_0000, "R10"); look(64'h8000_0000, "R10");
        wr(6'd40, 64'hC000_0000_0000_0000, "R10");
        look(64'h4000_0000, "R10"); look(64'h8000_0010, "R10");

        // Phase C: register-window protection only
        do_reset("R9");
        wr(6'd40, 64'h2000_0000_0000_0000, "R7");
        wr(6'd8, 64'hFFFF_FFF0_0000_0000, "R7");
        look(64'h1_0000_0800, "R7");
        wr(6'd32, 64'h0000_8000_0000_0000, "R7");
        rd(6'd32, "R7");
        look(64'h1_0000_0800, "R10");
        step(0, 0, 0, 0, 0, 0, "R7");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule